// File: doc/BRIEF.md
# Quadrature Phase Interpolator Code Controller

This block turns up/down phase-rotation commands into the control word of a 360-degree quadrature phase interpolator. The interpolator has four delay cells, and cell k is driven by the quadrature clock phase at k times 90 degrees. The block keeps a phase position with 128 steps per clock period. It decodes that position into two outputs. The first is a 2-bit coarse select that enables one adjacent pair of cells. The second is a 32-bit thermometer fine code, given in true and complement form, that sets how the weight is split inside the pair. Because the decoder drives the cells directly, no phase-select multiplexer is needed ahead of the interpolator.

The fine thermometer always counts the weight given to the odd-numbered cell of the active pair. Its direction therefore reverses from one quadrant to the next. As a result, every single step changes the number of set fine bits by exactly one, including steps across a quadrant boundary and across the wrap point. This keeps the phase transfer monotonic.

A limited-range mode is also provided for per-lane deskew. It stays between cells 0 and 1 and uses a 16-step thermometer that saturates at both ends.

Top module: `qpi_code_ctrl`

## Requirements
- R1: While rst_n is low, and at the first edge after it rises, phase_pos is 0, coarse_sel is 0, fine_therm is all zeros and fine_therm_n is all ones.
- R2: In full-range mode, a cycle with step_up high and step_dn low adds 1 to phase_pos, wrapping from 127 to 0. A cycle with step_dn high and step_up low subtracts 1, wrapping from 0 to 127.
- R3: In full-range mode, coarse_sel equals phase_pos[6:5]. Coarse value q enables cells q and (q+1) mod 4.
- R4: In full-range mode, let f = phase_pos[4:0]. The number of set fine bits is f when coarse_sel is even and 32-f when it is odd. That number is the weight on the odd-numbered cell of the pair, so every single step changes it by exactly 1.
- R5: With n set fine bits, fine_therm has bits 0 to n-1 set and all other bits clear. fine_therm_n is always the bitwise inverse of fine_therm.
- R6: load takes priority over the step inputs and sets phase_pos to load_pos. Step_up and step_dn high together leave phase_pos unchanged, and so does a cycle with neither high.
- R7: In limited-range mode (lim_mode high), phase_pos stays within 0..16. It saturates at 16 on step_up and at 0 on step_dn, and a load above 16 is clamped to 16. coarse_sel is 0, the number of set fine bits equals phase_pos, and fine bits 16 to 31 are clear.
- R8: In any cycle where lim_mode differs from its value in the previous cycle, phase_pos is cleared to 0. This takes priority over load and the step inputs.
- R9: All outputs are registered and change together at the clock edge that samples the command, so the coarse and fine codes never disagree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_up | input | 1 | Advance phase one step |
| step_dn | input | 1 | Retard phase one step |
| load | input | 1 | Load load_pos into the phase position |
| load_pos | input | 7 | Phase position to load |
| lim_mode | input | 1 | 1 = limited-range 16-step mode, 0 = full 360-degree mode |
| coarse_sel | output | 2 | Active cell pair |
| fine_therm | output | 32 | Fine thermometer code, weight on the odd cell |
| fine_therm_n | output | 32 | Complement of fine_therm |
| phase_pos | output | 7 | Current phase position |

## Verification
The bench builds the controller with its default parameters: 32 fine steps per quadrant and a 16-step limited range. With these values the 31-to-32, 63-to-64 and 127-to-0 boundaries can be reached within a few loads. It also reaches both limited-range stops and the clamp of an oversized load. The vector walk crosses each kind of quadrant edge in both directions, so the reversal of the thermometer direction is observed at the ports.

// File: rtl/qpi_code_ctrl.sv
module qpi_code_ctrl #(
  parameter int FINE_STEPS = 32,
  parameter int LIM_STEPS  = 16,
  localparam int FW = $clog2(FINE_STEPS),
  localparam int AW = FW + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step_up,
  input  logic                  step_dn,
  input  logic                  load,
  input  logic [AW-1:0]         load_pos,
  input  logic                  lim_mode,
  output logic [1:0]            coarse_sel,
  output logic [FINE_STEPS-1:0] fine_therm,
  output logic [FINE_STEPS-1:0] fine_therm_n,
  output logic [AW-1:0]         phase_pos
);
  localparam int CW = FW + 1;
  localparam logic [AW-1:0] LIM_TOP = AW'(LIM_STEPS);

  logic                  mode_q;
  logic [AW-1:0]         nxt;
  logic [AW-1:0]         load_eff;
  logic [CW-1:0]         cnt;
  logic [1:0]            q_nxt;
  logic [FW-1:0]         f_nxt;
  logic [FINE_STEPS-1:0] th_nxt;

  wire up_only = step_up & ~step_dn;
  wire dn_only = step_dn & ~step_up;

  assign load_eff = (lim_mode && load_pos > LIM_TOP) ? LIM_TOP : load_pos;
  assign q_nxt    = nxt[AW-1:FW];
  assign f_nxt    = nxt[FW-1:0];

  always_comb begin
    nxt = phase_pos;
    if (lim_mode != mode_q)
      nxt = '0;
    else if (load)
      nxt = load_eff;
    else if (up_only) begin
      if (!lim_mode || phase_pos != LIM_TOP) nxt = phase_pos + 1'b1;
    end else if (dn_only) begin
      if (!lim_mode || phase_pos != '0) nxt = phase_pos - 1'b1;
    end
  end

  always_comb begin
    if (lim_mode)
      cnt = nxt[CW-1:0];
    else if (q_nxt[0])
      cnt = CW'(FINE_STEPS) - {1'b0, f_nxt};
    else
      cnt = {1'b0, f_nxt};
  end

  for (genvar i = 0; i < FINE_STEPS; i++) begin : g_th
    assign th_nxt[i] = (32'(i) < 32'(cnt));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= 1'b0;
      phase_pos    <= '0;
      coarse_sel   <= '0;
      fine_therm   <= '0;
      fine_therm_n <= '1;
    end else begin
      mode_q       <= lim_mode;
      phase_pos    <= nxt;
      coarse_sel   <= lim_mode ? 2'd0 : q_nxt;
      fine_therm   <= th_nxt;
      fine_therm_n <= ~th_nxt;
    end
  end
endmodule

// File: rtl/qpi_code_ctrl_chk.sv
module qpi_code_ctrl_chk #(
  parameter int FINE_STEPS = 32,
  parameter int LIM_STEPS  = 16,
  localparam int FW = $clog2(FINE_STEPS),
  localparam int AW = FW + 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  step_up,
  input logic                  step_dn,
  input logic                  load,
  input logic                  lim_mode,
  input logic                  mode_q,
  input logic [1:0]            coarse_sel,
  input logic [FINE_STEPS-1:0] fine_therm,
  input logic [FINE_STEPS-1:0] fine_therm_n,
  input logic [AW-1:0]         phase_pos
);
  wire full_cmd = !lim_mode && !mode_q && !load;

  a_r5_complement: assert property (@(posedge clk) disable iff (!rst_n)
    fine_therm_n == ~fine_therm);

  a_r5_therm_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (fine_therm & (fine_therm + 1'b1)) == '0);

  a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (full_cmd && step_up && !step_dn) |=> phase_pos == $past(phase_pos) + 1'b1);

  a_r2_step_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (full_cmd && step_dn && !step_up) |=> phase_pos == $past(phase_pos) - 1'b1);

  a_r4_one_bit_move: assert property (@(posedge clk) disable iff (!rst_n)
    (full_cmd && (step_up ^ step_dn)) |=>
      (($countones(fine_therm) + 1 == $past($countones(fine_therm))) ||
       ($countones(fine_therm) == $past($countones(fine_therm)) + 1)));

  a_r3_coarse_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> coarse_sel == phase_pos[AW-1:FW]);

  a_r7_lim_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> (coarse_sel == 2'd0 && phase_pos <= AW'(LIM_STEPS) &&
                fine_therm[FINE_STEPS-1:LIM_STEPS] == '0));

  a_r8_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_mode != mode_q) |=> phase_pos == '0);
endmodule

bind qpi_code_ctrl qpi_code_ctrl_chk #(
  .FINE_STEPS(FINE_STEPS),
  .LIM_STEPS (LIM_STEPS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .step_up     (step_up),
  .step_dn     (step_dn),
  .load        (load),
  .lim_mode    (lim_mode),
  .mode_q      (mode_q),
  .coarse_sel  (coarse_sel),
  .fine_therm  (fine_therm),
  .fine_therm_n(fine_therm_n),
  .phase_pos   (phase_pos)
);

// File: tb/qpi_code_ctrl_test.sv
module qpi_code_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_up = 1'b0, step_dn = 1'b0, load = 1'b0, lim_mode = 1'b0;
  logic [6:0]  load_pos = '0;
  logic [1:0]  coarse_sel;
  logic [31:0] fine_therm, fine_therm_n;
  logic [6:0]  phase_pos;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  qpi_code_ctrl uut (
    .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
    .load(load), .load_pos(load_pos), .lim_mode(lim_mode),
    .coarse_sel(coarse_sel), .fine_therm(fine_therm),
    .fine_therm_n(fine_therm_n), .phase_pos(phase_pos)
  );

  // {load, load_pos, up, dn, lim, exp_pos, exp_coarse, exp_count}
  localparam int NV = 25;
  localparam logic [25:0] VEC [0:NV-1] = '{
    {1'b1, 7'd30,  1'b0, 1'b0, 1'b0, 7'd30,  2'd0, 6'd30},
    {1'b0, 7'd0,   1'b1, 1'b0, 1'b0, 7'd31,  2'd0, 6'd31},
    {1'b0, 7'd0,   1'b1, 1'b0, 1'b0, 7'd32,  2'd1, 6'd32},
    {1'b0, 7'd0,   1'b1, 1'b0, 1'b0, 7'd33,  2'd1, 6'd31},
    {1'b0, 7'd0,   1'b0, 1'b1, 1'b0, 7'd32,  2'd1, 6'd32},
    {1'b0, 7'd0,   1'b0, 1'b1, 1'b0, 7'd31,  2'd0, 6'd31},
    {1'b0, 7'd0,   1'b1, 1'b1, 1'b0, 7'd31,  2'd0, 6'd31},
    {1'b1, 7'd63,  1'b1, 1'b0, 1'b0, 7'd63,  2'd1, 6'd1},
    {1'b0, 7'd0,   1'b1, 1'b0, 1'b0, 7'd64,  2'd2, 6'd0},
    {1'b1, 7'd127, 1'b0, 1'b1, 1'b0, 7'd127, 2'd3, 6'd1},
    {1'b0, 7'd0,   1'b1, 1'b0, 1'b0, 7'd0,   2'd0, 6'd0},
    {1'b0, 7'd0,   1'b0, 1'b1, 1'b0, 7'd127, 2'd3, 6'd1},
    {1'b0, 7'd0,   1'b0, 1'b0, 1'b0, 7'd127, 2'd3, 6'd1},
    {1'b1, 7'd5,   1'b0, 1'b0, 1'b1, 7'd0,   2'd0, 6'd0},
    {1'b1, 7'd100, 1'b0, 1'b0, 1'b1, 7'd16,  2'd0, 6'd16},
    {1'b0, 7'd0,   1'b1, 1'b0, 1'b1, 7'd16,  2'd0, 6'd16},
    {1'b0, 7'd0,   1'b0, 1'b1, 1'b1, 7'd15,  2'd0, 6'd15},
    {1'b1, 7'd3,   1'b0, 1'b0, 1'b1, 7'd3,   2'd0, 6'd3},
    {1'b0, 7'd0,   1'b0, 1'b1, 1'b1, 7'd2,   2'd0, 6'd2},
    {1'b1, 7'd0,   1'b0, 1'b0, 1'b1, 7'd0,   2'd0, 6'd0},
    {1'b0, 7'd0,   1'b0, 1'b1, 1'b1, 7'd0,   2'd0, 6'd0},
    {1'b0, 7'd0,   1'b1, 1'b0, 1'b0, 7'd0,   2'd0, 6'd0},
    {1'b0, 7'd0,   1'b1, 1'b0, 1'b0, 7'd1,   2'd0, 6'd1},
    {1'b1, 7'd96,  1'b0, 1'b0, 1'b0, 7'd96,  2'd3, 6'd32},
    {1'b0, 7'd0,   1'b1, 1'b0, 1'b0, 7'd97,  2'd3, 6'd31}
  };

  localparam string TAGS [0:NV-1] = '{
    "R6 load", "R2 up", "R4 quadrant 0->1", "R4 odd quadrant", "R2 down",
    "R4 quadrant 1->0", "R6 both steps", "R6 load beats step", "R3 quadrant 1->2",
    "R6 load beats down", "R2 wrap up", "R2 wrap down", "R6 idle",
    "R8 mode change beats load", "R7 load clamp", "R7 top saturate", "R7 down",
    "R7 load", "R7 down", "R7 load zero", "R7 bottom saturate",
    "R8 mode exit beats step", "R9 first full step", "R3 quadrant 3", "R4 odd quadrant 3"
  };

  function automatic logic [31:0] therm(input int n);
    return 32'((64'd1 << n) - 64'd1);
  endfunction

  task automatic expect_out(input string tag, input logic [6:0] ep,
                            input logic [1:0] ec, input int en);
    logic [31:0] et;
    et = therm(en);
    checks++;
    if (phase_pos !== ep || coarse_sel !== ec || fine_therm !== et ||
        fine_therm_n !== ~et) begin
      errors++;
      $display("FAIL %s: pos=%0d coarse=%0d fine=%h fine_n=%h expected pos=%0d coarse=%0d fine=%h fine_n=%h",
               tag, phase_pos, coarse_sel, fine_therm, fine_therm_n, ep, ec, et, ~et);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R1 reset held", 7'd0, 2'd0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 first edge after reset", 7'd0, 2'd0, 0);

    for (int i = 0; i < NV; i++) begin
      {load, load_pos, step_up, step_dn, lim_mode} = VEC[i][25:15];
      @(negedge clk);
      expect_out(TAGS[i], VEC[i][14:8], VEC[i][7:6], int'(VEC[i][5:0]));
    end

    // R2 R4: walk up through a full period from 97, each step moves one fine bit
    {load, step_dn, lim_mode} = 3'b000;
    step_up = 1'b1;
    for (int k = 1; k <= 128; k++) begin
      int p, q, f, n;
      p = (97 + k) % 128;
      q = p / 32;
      f = p % 32;
      n = (q % 2 == 1) ? 32 - f : f;
      @(negedge clk);
      if (k % 16 == 0 || f == 0 || f == 31)
        expect_out("R4 full period walk", 7'(p), 2'(q), n);
    end
    step_up = 1'b0;

    // R9: command applied before an edge must not show before that edge
    load = 1'b1; load_pos = 7'd40;
    #1;
    expect_out("R9 no early change", 7'd97, 2'd3, 31);
    @(negedge clk);
    load = 1'b0;
    expect_out("R9 change at edge", 7'd40, 2'd1, 24);

    // R1: reset mid-run
    rst_n = 1'b0;
    #3;
    expect_out("R1 async reset", 7'd0, 2'd0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 after reset release", 7'd0, 2'd0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule